// File: doc/BRIEF.md
# Four-Slot Lock-Step Bundle Issue Stage

This block is the issue and execute stage of a wide-word processor. Each cycle it can accept one fixed-width bundle of four 16-bit slot fields. Every field position always feeds the same functional unit: slot 0 and slot 1 feed integer ALUs, slot 2 feeds a multiplier and slot 3 feeds the only load/store port. Operands come from a shared 16-entry register file. The stage never detects hazards and never reorders work. Program order and correctness are left to the code scheduler that built the bundle.

An accepted bundle sits in one execute register. A bundle with no memory operation retires one cycle after it is accepted. A bundle that holds a load or store raises a memory request and stays frozen, with every slot held, until the memory side signals ready. While it is frozen, the input handshake refuses new bundles. When the bundle retires, all four slots write back in the same cycle, and a retired-bundle counter increments.

Slot field layout, from most significant to least significant bit: opcode [15:12], destination [11:8], source A [7:4], source B [3:0]. Slot k occupies bundle bits [16k+15:16k].

Top module: `vliw_issue_stage`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows bundle_ready=1, mem_req=0 and retired_count=0, and every register reads as zero.
- R2: In ALU slots 0 and 1, the opcodes behave as follows. 1=ADD, 2=SUB (A-B), 3=AND, 4=OR, 5=XOR, 6=shift A left by B[4:0], 7=logical shift A right by B[4:0], 8=load immediate (destination gets the zero-extended 8-bit value {srcA field, srcB field}). In each case the destination receives the result when the bundle retires.
- R3: In multiplier slot 2, opcode 1 writes the low 32 bits of the unsigned product A*B, and opcode 2 writes the high 32 bits.
- R4: The following have no effect on registers or memory: opcode 0 in any slot, ALU opcodes 9-15, multiplier opcodes 0 and 3-15, and slot 3 opcodes other than 1 and 2. mem_req stays low for a bundle without a memory opcode.
- R5: Slot 3 opcode 1 is a load and opcode 2 is a store. Either one raises mem_req with mem_addr = R[srcA]. A store also drives mem_we=1 and mem_wdata = R[srcB]. A load writes mem_rdata into the destination when the bundle retires.
- R6: All slots read their operands from the register state before the bundle commits, so no slot sees a result written by another slot of the same bundle.
- R7: When several slots of one bundle write the same destination, the highest-numbered slot's value is kept.
- R8: While mem_req=1 and mem_ready=0, the bundle is frozen. bundle_ready is 0, mem_addr, mem_we and mem_wdata are stable, and retired_count does not change. Results from the other slots commit only together with the memory slot.
- R9: A bundle retires in the cycle where it has no memory operation or where mem_ready is 1. retired_count increments by exactly one per retired bundle. Bundles without memory operations can be accepted back to back, one per cycle.
- R10: Register 0 always reads zero, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bundle_valid | input | 1 | A bundle is offered |
| bundle_data | input | 64 | Four 16-bit slot fields, slot 0 in the low bits |
| bundle_ready | output | 1 | The stage takes the offered bundle at this edge |
| mem_req | output | 1 | A memory operation is pending |
| mem_we | output | 1 | The pending operation is a store |
| mem_addr | output | 32 | Memory address, R[srcA] of slot 3 |
| mem_wdata | output | 32 | Store data, R[srcB] of slot 3 |
| mem_ready | input | 1 | Memory completes the pending operation at this edge |
| mem_rdata | input | 32 | Load data, valid while mem_ready is 1 |
| retired_count | output | 32 | Number of bundles committed since reset |

## Verification
The properties assume that the memory side eventually raises mem_ready for every request. No property checks liveness, so a memory that never answers is caught only by the bench timeout. They also assume that mem_ready outside a request is harmless and that bundle inputs carry known values after reset. The stimulus meets these assumptions with a bench memory that answers each request after a chosen delay of zero to three cycles. It returns load data computed from the address, and it drives bundle fields drawn from opcode ranges that include the undefined codes.

// File: rtl/vliw_pkg.sv
// Package: opcode encodings shared by the units of the bundle issue stage.
// Assumes a 4-bit opcode field at the top of each 16-bit slot.
package vliw_pkg;
    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        ALU_NOP = 4'd0,
        ALU_ADD = 4'd1,
        ALU_SUB = 4'd2,
        ALU_AND = 4'd3,
        ALU_OR  = 4'd4,
        ALU_XOR = 4'd5,
        ALU_SHL = 4'd6,
        ALU_SHR = 4'd7,
        ALU_LDI = 4'd8
    } alu_op_e;

    typedef enum logic [OPC_W-1:0] {
        MUL_NOP = 4'd0,
        MUL_LO  = 4'd1,
        MUL_HI  = 4'd2
    } mul_op_e;

    typedef enum logic [OPC_W-1:0] {
        MEM_NOP   = 4'd0,
        MEM_LOAD  = 4'd1,
        MEM_STORE = 4'd2
    } mem_op_e;
endpackage

// File: rtl/vliw_regfile.sv
// Module: multi-ported register file.
// NRD combinational read ports and NWR write ports, written together on commit.
// Assumes entry 0 is constant zero. When several ports hit one entry, the highest port wins.
module vliw_regfile #(
    parameter int DATA_W = 32,
    parameter int AW     = 4,
    parameter int NRD    = 8,
    parameter int NWR    = 4,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_addr [NRD],
    output logic [DATA_W-1:0] rd_data [NRD],
    input  logic              commit,
    input  logic              wr_en   [NWR],
    input  logic [AW-1:0]     wr_addr [NWR],
    input  logic [DATA_W-1:0] wr_data [NWR]
);
    logic [DATA_W-1:0] regs [DEPTH];

    // Storage update: clear on reset, then apply the write ports in ascending order so the highest port wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (commit) begin
            for (int p = 0; p < NWR; p++) begin
                if (wr_en[p] && (wr_addr[p] != '0)) regs[wr_addr[p]] <= wr_data[p];
            end
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_read
        // Read port r: entry 0 is forced to zero.
        always_comb begin
            rd_data[r] = (rd_addr[r] == '0) ? '0 : regs[rd_addr[r]];
        end
    end
endmodule

// File: rtl/vliw_alu.sv
// Module: integer ALU for one bundle slot.
// Purely combinational. Undefined opcodes clear wen so nothing is written.
// Assumes shift amounts are taken from the low log2(DATA_W) bits of operand B.
module vliw_alu
    import vliw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [OPC_W-1:0]  opc,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [IMM_W-1:0]  imm,
    output logic              wen,
    output logic [DATA_W-1:0] result
);
    // Operation select: compute the result and flag whether the opcode is defined.
    always_comb begin
        wen    = 1'b1;
        result = '0;
        case (opc)
            ALU_ADD: result = op_a + op_b;
            ALU_SUB: result = op_a - op_b;
            ALU_AND: result = op_a & op_b;
            ALU_OR:  result = op_a | op_b;
            ALU_XOR: result = op_a ^ op_b;
            ALU_SHL: result = op_a << op_b[SH_W-1:0];
            ALU_SHR: result = op_a >> op_b[SH_W-1:0];
            ALU_LDI: result = {{(DATA_W-IMM_W){1'b0}}, imm};
            default: wen = 1'b0;
        endcase
    end
endmodule

// File: rtl/vliw_mul.sv
// Module: single-cycle unsigned multiplier for the multiplier slot.
// Produces the low or high half of the full product. Other opcodes write nothing.
module vliw_mul
    import vliw_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic [OPC_W-1:0]  opc,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              wen,
    output logic [DATA_W-1:0] result
);
    logic [PROD_W-1:0] product;

    // Full-width product of the two operands.
    always_comb begin
        product = PROD_W'(op_a) * PROD_W'(op_b);
    end

    // Half select and write flag.
    always_comb begin
        wen    = 1'b1;
        result = '0;
        case (opc)
            MUL_LO:  result = product[DATA_W-1:0];
            MUL_HI:  result = product[PROD_W-1:DATA_W];
            default: wen = 1'b0;
        endcase
    end
endmodule

// File: rtl/vliw_lsu.sv
// Module: the single load/store port of the bundle.
// Raises a request while a valid memory opcode sits in execute, and reports done when memory is ready.
// Assumes mem_rdata is valid whenever mem_ready is high during a load.
module vliw_lsu
    import vliw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              ex_valid,
    input  logic [OPC_W-1:0]  opc,
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] store_val,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              done,
    output logic              wen,
    output logic [DATA_W-1:0] result
);
    logic is_load;
    logic is_store;

    // Opcode decode: any code other than load or store acts as a no-operation.
    always_comb begin
        is_load  = (opc == MEM_LOAD);
        is_store = (opc == MEM_STORE);
    end

    // Memory request outputs, held as long as the execute bundle is held.
    always_comb begin
        mem_req   = ex_valid && (is_load || is_store);
        mem_we    = ex_valid && is_store;
        mem_addr  = base;
        mem_wdata = store_val;
    end

    // Completion and load write-back.
    always_comb begin
        done   = !(is_load || is_store) || mem_ready;
        wen    = is_load;
        result = mem_rdata;
    end
endmodule

// File: rtl/vliw_issue_stage.sv
// Module: four-slot lock-step bundle issue and execute stage.
// Slot 0/1 -> ALUs, slot 2 -> multiplier, slot 3 -> load/store port, with fixed wiring.
// There is no interlock. All slots read the pre-commit state, and all commit together at retire.
// A pending memory slot freezes the whole bundle and the input handshake.
module vliw_issue_stage
    import vliw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 4,
    parameter int CNT_W  = 32,
    localparam int NUM_SLOTS = 4,
    localparam int SLOT_W    = OPC_W + 3 * REG_AW,
    localparam int BUNDLE_W  = NUM_SLOTS * SLOT_W,
    localparam int IMM_W     = 2 * REG_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bundle_valid,
    input  logic [BUNDLE_W-1:0] bundle_data,
    output logic                bundle_ready,
    output logic                mem_req,
    output logic                mem_we,
    output logic [DATA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_ready,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [CNT_W-1:0]    retired_count
);
    localparam int SLOT_ALU0 = 0;
    localparam int SLOT_ALU1 = 1;
    localparam int SLOT_MUL  = 2;
    localparam int SLOT_MEM  = 3;

    logic                ex_valid;
    logic [BUNDLE_W-1:0] ex_bundle;
    logic                retire;
    logic                lsu_done;

    logic [OPC_W-1:0]  f_opc [NUM_SLOTS];
    logic [REG_AW-1:0] f_rd  [NUM_SLOTS];
    logic [REG_AW-1:0] f_ra  [NUM_SLOTS];
    logic [REG_AW-1:0] f_rb  [NUM_SLOTS];

    logic [REG_AW-1:0] rf_raddr [2*NUM_SLOTS];
    logic [DATA_W-1:0] rf_rdata [2*NUM_SLOTS];
    logic              wb_en    [NUM_SLOTS];
    logic [REG_AW-1:0] wb_addr  [NUM_SLOTS];
    logic [DATA_W-1:0] wb_data  [NUM_SLOTS];

    // Slot field extraction and operand read addresses, repeated per slot.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_comb begin
            f_opc[s] = ex_bundle[s*SLOT_W + 3*REG_AW +: OPC_W];
            f_rd[s]  = ex_bundle[s*SLOT_W + 2*REG_AW +: REG_AW];
            f_ra[s]  = ex_bundle[s*SLOT_W + REG_AW   +: REG_AW];
            f_rb[s]  = ex_bundle[s*SLOT_W            +: REG_AW];
            rf_raddr[2*s]   = f_ra[s];
            rf_raddr[2*s+1] = f_rb[s];
            wb_addr[s]      = f_rd[s];
        end
    end

    // Handshake: take a new bundle when the stage is empty or the current one retires now.
    always_comb begin
        retire       = ex_valid && lsu_done;
        bundle_ready = !ex_valid || retire;
    end

    // Execute register: holds the bundle in lock-step until it retires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_valid  <= 1'b0;
            ex_bundle <= '0;
        end else if (bundle_ready) begin
            ex_valid <= bundle_valid;
            if (bundle_valid) ex_bundle <= bundle_data;
        end
    end

    // Retired-bundle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) retired_count <= '0;
        else if (retire) retired_count <= retired_count + CNT_W'(1);
    end

    vliw_regfile #(
        .DATA_W (DATA_W),
        .AW     (REG_AW),
        .NRD    (2*NUM_SLOTS),
        .NWR    (NUM_SLOTS)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rf_raddr),
        .rd_data (rf_rdata),
        .commit  (retire),
        .wr_en   (wb_en),
        .wr_addr (wb_addr),
        .wr_data (wb_data)
    );

    for (genvar a = SLOT_ALU0; a <= SLOT_ALU1; a++) begin : g_alu
        vliw_alu #(
            .DATA_W (DATA_W),
            .IMM_W  (IMM_W)
        ) u_alu (
            .opc    (f_opc[a]),
            .op_a   (rf_rdata[2*a]),
            .op_b   (rf_rdata[2*a+1]),
            .imm    ({f_ra[a], f_rb[a]}),
            .wen    (wb_en[a]),
            .result (wb_data[a])
        );
    end

    vliw_mul #(
        .DATA_W (DATA_W)
    ) u_mul (
        .opc    (f_opc[SLOT_MUL]),
        .op_a   (rf_rdata[2*SLOT_MUL]),
        .op_b   (rf_rdata[2*SLOT_MUL+1]),
        .wen    (wb_en[SLOT_MUL]),
        .result (wb_data[SLOT_MUL])
    );

    vliw_lsu #(
        .DATA_W (DATA_W)
    ) u_lsu (
        .ex_valid  (ex_valid),
        .opc       (f_opc[SLOT_MEM]),
        .base      (rf_rdata[2*SLOT_MEM]),
        .store_val (rf_rdata[2*SLOT_MEM+1]),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (lsu_done),
        .wen       (wb_en[SLOT_MEM]),
        .result    (wb_data[SLOT_MEM])
    );
endmodule

// File: rtl/vliw_issue_checker.sv
// Module: port-level properties of the bundle issue stage, attached by bind.
// Assumes the memory side eventually answers every request. No liveness is checked.
module vliw_issue_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bundle_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic [CNT_W-1:0]  retired_count
);
    // R1: a reset edge leaves the stage idle and the counter cleared.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (retired_count == '0) && !mem_req && bundle_ready);

    // R8: a frozen bundle blocks the input handshake.
    p_freeze_blocks_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |-> !bundle_ready);

    // R8: a frozen request keeps its address, direction and data.
    p_freeze_holds_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R8: nothing retires during a freeze.
    p_freeze_no_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> $stable(retired_count));

    // R9: a completed memory bundle retires exactly once.
    p_mem_retire_counts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (retired_count == $past(retired_count) + CNT_W'(1)));

    // R9: the counter advances by at most one per cycle.
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((retired_count - $past(retired_count)) <= CNT_W'(1)));
endmodule

bind vliw_issue_stage vliw_issue_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bundle_ready  (bundle_ready),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ready     (mem_ready),
    .retired_count (retired_count)
);

// File: tb/vliw_issue_stage_test.sv
// Bench: directed corner cases plus seeded random bundles, checked against a reference register model.
module vliw_issue_stage_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bundle_valid = 1'b0;
    logic [63:0] bundle_data = '0;
    logic        bundle_ready;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] retired_count;

    int checks = 0;
    int errors = 0;
    int mem_delay = 0;
    int stall_cnt = 0;
    logic [31:0] exp_count = '0;
    logic [31:0] ref_rf [16];

    always #5 clk = ~clk;

    vliw_issue_stage uut (
        .clk(clk), .rst_n(rst_n), .bundle_valid(bundle_valid), .bundle_data(bundle_data),
        .bundle_ready(bundle_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .retired_count(retired_count)
    );

    function automatic logic [31:0] load_val(input logic [31:0] addr);
        return (addr * 32'd3) ^ 32'h5A5A_0000;
    endfunction

    // Bench memory: answers after mem_delay waiting cycles, with data computed from the address.
    assign mem_ready = mem_req && (stall_cnt >= mem_delay);
    assign mem_rdata = load_val(mem_addr);
    always @(posedge clk) begin
        if (!mem_req || mem_ready) stall_cnt <= 0;
        else stall_cnt <= stall_cnt + 1;
    end

    function automatic logic [15:0] mk(input int opc, input int rd, input int ra, input int rb);
        return {opc[3:0], rd[3:0], ra[3:0], rb[3:0]};
    endfunction

    function automatic logic [63:0] bun(input logic [15:0] s0, input logic [15:0] s1,
                                        input logic [15:0] s2, input logic [15:0] s3);
        return {s3, s2, s1, s0};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference commit: every slot reads the old state, and later slots overwrite earlier ones.
    task automatic apply_ref(input logic [63:0] b);
        logic [31:0] old [16];
        for (int i = 0; i < 16; i++) old[i] = ref_rf[i];
        for (int s = 0; s < 4; s++) begin
            logic [15:0] f;
            logic [31:0] a, bb, res;
            logic [63:0] prod;
            logic w;
            f = b[s*16 +: 16];
            a = old[f[7:4]];
            bb = old[f[3:0]];
            w = 1'b1;
            res = '0;
            prod = 64'(a) * 64'(bb);
            if (s < 2) begin
                case (f[15:12])
                    4'd1: res = a + bb;
                    4'd2: res = a - bb;
                    4'd3: res = a & bb;
                    4'd4: res = a | bb;
                    4'd5: res = a ^ bb;
                    4'd6: res = a << bb[4:0];
                    4'd7: res = a >> bb[4:0];
                    4'd8: res = {24'd0, f[7:0]};
                    default: w = 1'b0;
                endcase
            end else if (s == 2) begin
                case (f[15:12])
                    4'd1: res = prod[31:0];
                    4'd2: res = prod[63:32];
                    default: w = 1'b0;
                endcase
            end else begin
                w = (f[15:12] == 4'd1);
                res = load_val(a);
            end
            if (w && f[11:8] != 4'd0) ref_rf[f[11:8]] = res;
        end
    endtask

    // Issue one bundle, follow it to retirement and check the memory side, freeze and counter.
    task automatic run_bundle(input logic [63:0] b, input int delay, input string tag);
        logic [15:0] m;
        logic ismem, isst;
        logic [31:0] ea, ed;
        m = b[63:48];
        isst = (m[15:12] == 4'd2);
        ismem = (m[15:12] == 4'd1) || isst;
        ea = ref_rf[m[7:4]];
        ed = ref_rf[m[3:0]];
        mem_delay = delay;
        @(negedge clk);
        bundle_valid = 1'b1;
        bundle_data = b;
        @(negedge clk);
        bundle_valid = 1'b0;
        check(mem_req === ismem, tag, 32'(mem_req), 32'(ismem));
        if (ismem) begin
            check(mem_addr === ea, tag, mem_addr, ea);
            check(mem_we === isst, tag, 32'(mem_we), 32'(isst));
            if (isst) check(mem_wdata === ed, tag, mem_wdata, ed);
            for (int i = 0; i < delay; i++) begin
                check(bundle_ready === 1'b0, "R8 ready during freeze", 32'(bundle_ready), 32'd0);
                check(retired_count === exp_count, "R8 count during freeze", retired_count, exp_count);
                @(negedge clk);
                check(mem_addr === ea, "R8 address held", mem_addr, ea);
            end
        end
        check(bundle_ready === 1'b1, "R9 ready at retire", 32'(bundle_ready), 32'd1);
        @(negedge clk);
        apply_ref(b);
        exp_count = exp_count + 32'd1;
        check(retired_count === exp_count, "R9 retired count", retired_count, exp_count);
    endtask

    // Read a register out through a store to address R0 (which is 0).
    task automatic peek(input int r, input string tag);
        run_bundle(bun(16'h0, 16'h0, 16'h0, mk(2, 0, 0, r)), 0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual %h expected %h", 32'd0, 32'd1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) ref_rf[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(bundle_ready === 1'b1, "R1 ready", 32'(bundle_ready), 32'd1);
        check(mem_req === 1'b0, "R1 mem_req", 32'(mem_req), 32'd0);
        check(retired_count === 32'd0, "R1 count", retired_count, 32'd0);
        rst_n = 1'b1;
        peek(5, "R1 register zero");
        peek(15, "R1 register zero");

        // R2 immediates and ALU operations
        run_bundle(bun(mk(8, 1, 1, 2), mk(8, 2, 3, 4), 16'h0, 16'h0), 0, "R2");
        peek(1, "R2 load immediate");
        peek(2, "R2 load immediate");
        run_bundle(bun(mk(1, 3, 1, 2), mk(2, 4, 1, 2), 16'h0, 16'h0), 0, "R2");
        peek(3, "R2 add");
        peek(4, "R2 sub");
        run_bundle(bun(mk(6, 5, 1, 2), mk(7, 6, 4, 2), 16'h0, 16'h0), 0, "R2");
        peek(5, "R2 shift left");
        peek(6, "R2 shift right");

        // R3 multiplier halves
        run_bundle(bun(16'h0, 16'h0, mk(1, 7, 3, 3), 16'h0), 0, "R3");
        peek(7, "R3 mul low");
        run_bundle(bun(16'h0, 16'h0, mk(2, 8, 4, 4), 16'h0), 0, "R3");
        peek(8, "R3 mul high");

        // R4 no-effect encodings: undefined ALU, multiplier and memory-slot opcodes aimed at r1
        run_bundle(bun(mk(12, 1, 3, 3), mk(0, 1, 3, 3), mk(3, 1, 3, 3), mk(5, 1, 3, 3)), 0, "R4 no mem request");
        peek(1, "R4 register unchanged");
        run_bundle(64'h0, 0, "R4 all nop");

        // R5 store and load
        run_bundle(bun(16'h0, 16'h0, 16'h0, mk(2, 0, 1, 3)), 1, "R5 store");
        run_bundle(bun(16'h0, 16'h0, 16'h0, mk(1, 9, 2, 0)), 2, "R5 load");
        peek(9, "R5 load data");

        // R6 same-bundle results are invisible
        run_bundle(bun(mk(8, 10, 5, 5), mk(1, 11, 10, 0), 16'h0, 16'h0), 0, "R6");
        peek(11, "R6 old value read");

        // R7 highest slot wins
        run_bundle(bun(mk(8, 12, 0, 1), mk(8, 12, 0, 2), mk(1, 12, 1, 1), mk(1, 12, 2, 0)), 1, "R7");
        peek(12, "R7 memory slot wins");
        run_bundle(bun(mk(8, 13, 0, 1), mk(8, 13, 0, 2), mk(1, 13, 1, 1), 16'h0), 0, "R7");
        peek(13, "R7 multiplier wins");

        // R8 long freeze with ALU work in the same bundle
        run_bundle(bun(mk(8, 14, 7, 7), mk(1, 15, 1, 2), 16'h0, mk(1, 3, 1, 0)), 3, "R8");
        peek(14, "R8 deferred commit");
        peek(3, "R8 deferred load");

        // R10 register 0 stays zero
        run_bundle(bun(mk(8, 0, 15, 15), 16'h0, mk(1, 0, 2, 2), 16'h0), 0, "R10");
        peek(0, "R10 zero register");

        // R9 back-to-back bundles without memory operations
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            logic [63:0] b;
            b = bun(mk(1, 4, 4, 1), 16'h0, 16'h0, 16'h0);
            if (k > 0) begin
                check(bundle_ready === 1'b1, "R9 streaming ready", 32'(bundle_ready), 32'd1);
                apply_ref(bundle_data);
            end
            if (k > 1) begin
                exp_count = exp_count + 32'd1;
                check(retired_count === exp_count, "R9 streaming count", retired_count, exp_count);
            end
            bundle_valid = 1'b1;
            bundle_data = b;
            @(negedge clk);
        end
        bundle_valid = 1'b0;
        apply_ref(bundle_data);
        exp_count = exp_count + 32'd1;
        check(retired_count === exp_count, "R9 streaming count", retired_count, exp_count);
        @(negedge clk);
        exp_count = exp_count + 32'd1;
        check(retired_count === exp_count, "R9 streaming drain", retired_count, exp_count);
        peek(4, "R9 streamed result");

        // Random bundles across R2 R3 R4 R5 R7, with register sweeps
        for (int n = 0; n < 160; n++) begin
            logic [63:0] b;
            b = bun(mk($urandom % 11, $urandom % 16, $urandom % 16, $urandom % 16),
                    mk($urandom % 11, $urandom % 16, $urandom % 16, $urandom % 16),
                    mk($urandom % 4,  $urandom % 16, $urandom % 16, $urandom % 16),
                    mk($urandom % 4,  $urandom % 16, $urandom % 16, $urandom % 16));
            run_bundle(b, $urandom % 4, "R5 random bundle");
            if (n % 40 == 39) begin
                for (int r = 1; r < 16; r++) peek(r, "R2 random register sweep");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule